// File: doc/BRIEF.md
# Data Cache with Per-Access Write Policy

This block is a four-way set-associative data cache controller. Each line is 32 bytes and the data path is 64 bits wide. The requester issues one load or store at a time. Every access carries a policy attribute, and that attribute decides how the access is handled, both on a hit and on a miss:

- **Uncached** accesses go straight to memory.
- **Write-back** stores stay in the cache until the line is evicted.
- **Write-through** stores update the cache and are also copied to memory. On a miss the line is allocated first.

On the memory side there is one simple port. It carries four kinds of traffic: line fills, line evictions, single-word reads and single-word writes. Each entry of the data array keeps one even parity bit for each byte. Each tag keeps two parity bits: one over the address tag and one over the 2-bit line state.

The block is used between a load/store unit and the next level of memory. Software picks the policy per access, for example uncached for device windows, write-through for frame buffers and write-back for ordinary data.

Top module: `dcache_wpol`

## Requirements
- R1: An uncached read (policy 00) issues one word read (mem_cmd 01) and returns the memory word. It issues no line read (mem_cmd 00), and it returns memory data even when the same address is resident in the cache.
- R2: An uncached write (policy 00) issues one write beat (mem_cmd 10) with the store's address, data and byte enables. It leaves every cache line unchanged, so a later cached load of that address still returns the cached value.
- R3: A write-back load (policy 01) that hits returns the array data with no memory traffic. A load that misses issues one line read at the line-aligned address, takes four beats in order beat 0 to beat 3, and then returns the requested word.
- R4: A write-back store that hits updates the line and sets its state to dirty, with no memory traffic. The state field uses invalid = 00, clean = 01 and dirty = 11, and never holds 10.
- R5: A write-back store that misses first fills the whole line, then performs the store into it. It issues no write to memory unless a dirty victim must be evicted.
- R6: A write-through store (policy 10) updates the resident line, or allocates the line first on a miss. It also issues one write beat carrying the same address, data and byte enables. The response comes only after that beat is accepted.
- R7: A store changes only the bytes whose bit is set in the 8-bit byte enable (bit b covers data bits 8b+7..8b). All other bytes keep their previous value.
- R8: On a miss, the victim is the lowest-numbered invalid way. If no way is invalid, the victim is the way named by the set's 2-bit rotation counter. That counter starts at 0 and advances by one on every line allocation in the set.
- R9: A dirty victim is written out as four write beats with all byte enables set, at the victim's line address plus 0, 8, 16 and 24 in that order. All four beats go out before the line read for the new line is issued. A clean victim is replaced with no write.
- R10: resp_rpar carries the even parity of each byte of resp_rdata (bit b is the XOR of byte b). On a hit this parity comes from the parity bits stored in the array.
- R11: After reset every line is invalid, req_ready is 1 and no memory request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Controller idle; the request is accepted this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_policy | input | 2 | 00 uncached, 01 write-back, 10 write-through with allocate |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 64 | Store data |
| req_be | input | 8 | Store byte enables |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 64 | Load data |
| resp_rpar | output | 8 | Per-byte parity of resp_rdata |
| mem_req_valid | output | 1 | Memory request |
| mem_req_ready | input | 1 | Memory accepts the request or write beat |
| mem_cmd | output | 2 | 00 line read, 01 word read, 10 write beat |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 64 | Write beat data |
| mem_be | output | 8 | Write beat byte enables |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rdata | input | 64 | Read beat data |

## Verification
Five distinct tags are aimed at one set. This forces a dirty line to be the rotation victim. The test checks the order of the four eviction beats and checks that they all come before the fill. A design that fetched first would lose the store, and a design with the wrong counter would evict the wrong way.

An uncached read and an uncached write are aimed at a dirty resident line. A controller that looked up the cache on uncached reads would return the cached copy. One that updated the cache on uncached writes would corrupt data that the later eviction restores.

Random mixes of write-back and write-through stores with partial byte enables follow. Each load and each memory word is compared with a byte-merged expected image, which catches wrong byte merging and missing or unexpected write-through beats.

// File: rtl/dcache_wpol.sv
module dcache_wpol #(
  parameter int ADDR_W = 12,
  parameter int SETS   = 4,
  parameter int WAYS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_policy,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_wdata,
  input  logic [7:0]        req_be,
  output logic              resp_valid,
  output logic [63:0]       resp_rdata,
  output logic [7:0]        resp_rpar,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [1:0]        mem_cmd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [63:0]       mem_wdata,
  output logic [7:0]        mem_be,
  input  logic              mem_rvalid,
  input  logic [63:0]       mem_rdata
);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - 5 - IDX_W;
  localparam int LINES = SETS * WAYS;
  localparam logic [1:0] INV = 2'b00, CLEAN = 2'b01, DIRTY = 2'b11;

  typedef enum logic [2:0] {S_IDLE, S_LOOK, S_EVICT, S_FREQ, S_FILL, S_UREAD, S_URESP, S_WWORD} st_e;
  st_e state;

  logic [71:0]      dat_q [LINES*4];
  logic [TAG_W-1:0] tag_q [LINES];
  logic [1:0]       ln_q  [LINES];
  logic [1:0]       tpar_q[LINES];
  logic [WAY_W-1:0] rr_q  [SETS];

  logic [ADDR_W-1:0] r_addr;
  logic [63:0]       r_wdata;
  logic [7:0]        r_be;
  logic              r_write;
  logic [1:0]        r_pol;
  logic [1:0]        beat_q;
  logic [WAY_W-1:0]  way_q;
  logic [2:0]        ev_cnt;

  function automatic logic [7:0] bpar(input logic [63:0] d);
    for (int b = 0; b < 8; b++) bpar[b] = ^d[8*b +: 8];
  endfunction

  wire [IDX_W-1:0] r_idx  = r_addr[5 +: IDX_W];
  wire [TAG_W-1:0] r_tag  = r_addr[ADDR_W-1 -: TAG_W];
  wire [1:0]       r_beat = r_addr[4:3];

  logic [WAYS-1:0]  hit_v;
  logic [WAY_W-1:0] hw, vic;
  logic             any_inv;
  for (genvar w = 0; w < WAYS; w++) begin : g_hit
    assign hit_v[w] = ln_q[{r_idx, WAY_W'(w)}] != INV && tag_q[{r_idx, WAY_W'(w)}] == r_tag;
  end

  always_comb begin
    hw = '0; vic = rr_q[r_idx]; any_inv = 1'b0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (hit_v[w]) hw = WAY_W'(w);
      if (ln_q[{r_idx, WAY_W'(w)}] == INV) begin vic = WAY_W'(w); any_inv = 1'b1; end
    end
  end

  wire hit = |hit_v;
  wire [IDX_W+WAY_W+1:0] h_di = {r_idx, hw, r_beat};
  wire [IDX_W+WAY_W-1:0] h_li = {r_idx, hw};
  wire [IDX_W+WAY_W-1:0] v_li = {r_idx, way_q};

  logic [63:0] merged;
  always_comb
    for (int b = 0; b < 8; b++)
      merged[8*b +: 8] = r_be[b] ? r_wdata[8*b +: 8] : dat_q[h_di][8*b +: 8];

  assign req_ready = state == S_IDLE;

  always_comb begin
    mem_req_valid = 1'b0; mem_cmd = 2'b10; mem_addr = r_addr;
    mem_wdata = r_wdata; mem_be = r_be;
    case (state)
      S_EVICT: begin
        mem_req_valid = 1'b1;
        mem_addr  = {tag_q[v_li], r_idx, beat_q, 3'b000};
        mem_wdata = dat_q[{v_li, beat_q}][63:0];
        mem_be    = 8'hFF;
      end
      S_FREQ:  begin mem_req_valid = 1'b1; mem_cmd = 2'b00; mem_addr = {r_tag, r_idx, 5'b0}; end
      S_UREAD: begin mem_req_valid = 1'b1; mem_cmd = 2'b01; end
      S_WWORD: mem_req_valid = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; resp_valid <= 1'b0; resp_rdata <= '0; resp_rpar <= '0;
      r_addr <= '0; r_wdata <= '0; r_be <= '0; r_write <= 1'b0; r_pol <= '0;
      beat_q <= '0; way_q <= '0; ev_cnt <= '0;
      for (int i = 0; i < LINES; i++) begin ln_q[i] <= INV; tag_q[i] <= '0; tpar_q[i] <= '0; end
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
    end else begin
      resp_valid <= 1'b0;
      if (state == S_IDLE) ev_cnt <= '0;
      else if (state == S_EVICT && mem_req_ready) ev_cnt <= ev_cnt + 3'd1;
      case (state)
        S_IDLE: if (req_valid) begin
          r_addr <= req_addr; r_wdata <= req_wdata; r_be <= req_be;
          r_write <= req_write; r_pol <= req_policy; state <= S_LOOK;
        end
        S_LOOK:
          if (r_pol == 2'b00) state <= r_write ? S_WWORD : S_UREAD;
          else if (hit) begin
            if (r_write) begin
              dat_q[h_di] <= {bpar(merged), merged};
              if (r_pol == 2'b01) begin
                ln_q[h_li] <= DIRTY; tpar_q[h_li] <= {^DIRTY, ^r_tag};
                resp_valid <= 1'b1; state <= S_IDLE;
              end else state <= S_WWORD;
            end else begin
              resp_rdata <= dat_q[h_di][63:0]; resp_rpar <= dat_q[h_di][71:64];
              resp_valid <= 1'b1; state <= S_IDLE;
            end
          end else begin
            way_q <= vic; beat_q <= '0;
            state <= (!any_inv && ln_q[{r_idx, vic}] == DIRTY) ? S_EVICT : S_FREQ;
          end
        S_EVICT: if (mem_req_ready) begin
          beat_q <= beat_q + 2'd1;
          if (beat_q == 2'd3) state <= S_FREQ;
        end
        S_FREQ: if (mem_req_ready) begin beat_q <= '0; state <= S_FILL; end
        S_FILL: if (mem_rvalid) begin
          dat_q[{v_li, beat_q}] <= {bpar(mem_rdata), mem_rdata};
          beat_q <= beat_q + 2'd1;
          if (beat_q == 2'd3) begin
            tag_q[v_li] <= r_tag; ln_q[v_li] <= CLEAN; tpar_q[v_li] <= {^CLEAN, ^r_tag};
            rr_q[r_idx] <= rr_q[r_idx] + 1'b1;
            state <= S_LOOK;
          end
        end
        S_UREAD: if (mem_req_ready) state <= S_URESP;
        S_URESP: if (mem_rvalid) begin
          resp_rdata <= mem_rdata; resp_rpar <= bpar(mem_rdata);
          resp_valid <= 1'b1; state <= S_IDLE;
        end
        S_WWORD: if (mem_req_ready) begin resp_valid <= 1'b1; state <= S_IDLE; end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_unc_no_fill_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_cmd == 2'b00 |-> r_pol != 2'b00);

  assert_wb_hit_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_LOOK && r_write && r_pol == 2'b01 && hit |=> !mem_req_valid);

  assert_state_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_LOOK |-> ln_q[{r_idx, vic}] != 2'b10 && ln_q[h_li] != 2'b10);

  assert_wt_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && r_write && r_pol == 2'b10 |-> $past(mem_req_valid && mem_req_ready && mem_cmd == 2'b10));

  assert_evict_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_cmd == 2'b00 && ln_q[v_li] == DIRTY |-> ev_cnt == 3'd4);

  assert_hit_parity_R10: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_LOOK && hit && r_pol != 2'b00 |->
      dat_q[h_di][71:64] == bpar(dat_q[h_di][63:0]) && tpar_q[h_li] == {^ln_q[h_li], ^tag_q[h_li]});
endmodule

// File: tb/dcache_wpol_tb.sv
`timescale 1ns/1ps
module dcache_wpol_tb;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic req_valid = 0, req_write = 0;
  logic [1:0] req_policy = 0;
  logic [11:0] req_addr = 0;
  logic [63:0] req_wdata = 0;
  logic [7:0] req_be = 0;
  logic req_ready, resp_valid, mem_req_valid;
  logic [63:0] resp_rdata, mem_wdata;
  logic [7:0] resp_rpar, mem_be;
  logic [1:0] mem_cmd;
  logic [11:0] mem_addr;
  logic mem_req_ready, mem_rvalid;
  logic [63:0] mem_rdata;

  dcache_wpol u_dut (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_policy(req_policy), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .resp_valid(resp_valid), .resp_rdata(resp_rdata), .resp_rpar(resp_rpar),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_cmd(mem_cmd),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata));

  logic [63:0] mem [512];
  logic [63:0] gold [512];
  int n_lr = 0, n_wr = 0, n_rw = 0, lr_wr_at = 0, pend = 0;
  logic [8:0] pa;
  logic [11:0] wlog [4];
  int checks = 0, fails = 0;

  function automatic logic [63:0] merge(input logic [63:0] o, input logic [63:0] d, input logic [7:0] be);
    for (int b = 0; b < 8; b++) merge[8*b +: 8] = be[b] ? d[8*b +: 8] : o[8*b +: 8];
  endfunction
  function automatic logic [7:0] bp(input logic [63:0] d);
    for (int b = 0; b < 8; b++) bp[b] = ^d[8*b +: 8];
  endfunction
  function automatic logic [63:0] bemask(input logic [7:0] be);
    for (int b = 0; b < 8; b++) bemask[8*b +: 8] = {8{be[b]}};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_rvalid <= 0; mem_req_ready <= 0; pend <= 0; mem_rdata <= 0; pa <= 0;
    end else begin
      mem_req_ready <= ($urandom_range(3) != 0);
      mem_rvalid <= 0;
      if (pend > 0 && $urandom_range(2) != 0) begin
        mem_rvalid <= 1; mem_rdata <= mem[pa]; pa <= pa + 1; pend <= pend - 1;
      end
      if (mem_req_valid && mem_req_ready) begin
        case (mem_cmd)
          2'b00: begin pa <= mem_addr[11:3]; pend <= 4; n_lr <= n_lr + 1; lr_wr_at <= n_wr; end
          2'b01: begin pa <= mem_addr[11:3]; pend <= 1; n_rw <= n_rw + 1; end
          default: begin
            mem[mem_addr[11:3]] <= merge(mem[mem_addr[11:3]], mem_wdata, mem_be);
            n_wr <= n_wr + 1;
            wlog[0] <= wlog[1]; wlog[1] <= wlog[2]; wlog[2] <= wlog[3]; wlog[3] <= mem_addr;
          end
        endcase
      end
    end
  end

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s: actual=%h expected=%h", req, act, exp); end
  endtask

  logic [63:0] rd;
  logic [7:0] rp;
  int d_lr, d_wr, d_rw, d_lrwr;

  task automatic op(input logic [1:0] pol, input bit wr, input logic [11:0] a,
                    input logic [63:0] d, input logic [7:0] be);
    int s_lr, s_wr, s_rw;
    @(negedge clk);
    s_lr = n_lr; s_wr = n_wr; s_rw = n_rw;
    req_valid = 1; req_write = wr; req_policy = pol; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 0;
    do @(negedge clk); while (!resp_valid);
    rd = resp_rdata; rp = resp_rpar;
    d_lr = n_lr - s_lr; d_wr = n_wr - s_wr; d_rw = n_rw - s_rw; d_lrwr = lr_wr_at - s_wr;
    if (wr && (pol != 2'b00 || a[11])) gold[a[11:3]] = merge(gold[a[11:3]], d, be);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < 512; i++) begin
      mem[i] = {32'hA5A5_0000 | 32'(i), ~32'(i * 7)};
      gold[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    chk(req_ready == 1 && mem_req_valid == 0, "R11 reset idle", {62'b0, req_ready, mem_req_valid}, 64'h2);
    rst_n = 1;

    op(2'b01, 0, 12'h000, 0, 0);
    chk(rd == gold[0] && d_lr == 1, "R3 wb load miss", rd, gold[0]);
    chk(rp == bp(gold[0]), "R10 parity on fill", {56'b0, rp}, {56'b0, bp(gold[0])});
    op(2'b01, 0, 12'h008, 0, 0);
    chk(rd == gold[1] && d_lr == 0 && d_rw == 0 && d_wr == 0, "R3 wb load hit quiet", rd, gold[1]);
    chk(rp == bp(gold[1]), "R10 parity on hit", {56'b0, rp}, {56'b0, bp(gold[1])});
    op(2'b01, 1, 12'h008, 64'h1122_3344_5566_7788, 8'h0F);
    chk(d_wr == 0 && d_lr == 0, "R4 wb store hit no traffic", 64'(d_wr + d_lr), 0);
    op(2'b01, 0, 12'h008, 0, 0);
    chk(rd == gold[1] && d_lr == 0, "R7 byte enable merge", rd, gold[1]);
    op(2'b00, 0, 12'h008, 0, 0);
    chk(rd == mem[1] && d_rw == 1 && d_lr == 0, "R1 uncached read bypass", rd, mem[1]);
    op(2'b00, 1, 12'h010, 64'hDEAD_BEEF_0000_1111, 8'hFF);
    chk(d_wr == 1 && mem[2] == 64'hDEAD_BEEF_0000_1111, "R2 uncached write to memory", mem[2], 64'hDEAD_BEEF_0000_1111);
    op(2'b01, 0, 12'h010, 0, 0);
    chk(rd == gold[2] && d_lr == 0, "R2 uncached write left line", rd, gold[2]);

    op(2'b10, 1, 12'h088, 64'hCAFE_0000_0000_ABCD, 8'hC3);
    chk(d_lr == 1 && d_wr == 1 && mem[12'h088 >> 3] == gold[12'h088 >> 3], "R6 wt store miss", mem[12'h088 >> 3], gold[12'h088 >> 3]);
    op(2'b01, 0, 12'h088, 0, 0);
    chk(rd == gold[12'h088 >> 3] && d_lr == 0, "R6 wt line allocated", rd, gold[12'h088 >> 3]);
    op(2'b01, 1, 12'h110, 64'h0BAD_F00D_1234_5678, 8'hF0);
    chk(d_lr == 1 && d_wr == 0, "R5 wb store miss fill no write", 64'(d_lr * 16 + d_wr), 64'h10);
    op(2'b01, 0, 12'h110, 0, 0);
    chk(rd == gold[12'h110 >> 3] && d_lr == 0, "R5 store written after fill", rd, gold[12'h110 >> 3]);
    op(2'b01, 0, 12'h180, 0, 0);
    chk(d_lr == 1 && d_wr == 0, "R8 fourth way invalid used", 64'(d_wr), 0);
    op(2'b01, 0, 12'h200, 0, 0);
    chk(d_wr == 4 && d_lrwr == 4 && d_lr == 1, "R9 dirty evict before fill", 64'(d_lrwr), 4);
    chk(wlog[0] == 12'h000 && wlog[1] == 12'h008 && wlog[2] == 12'h010 && wlog[3] == 12'h018,
        "R9 evict beat order", {16'(wlog[0]), 16'(wlog[1]), 16'(wlog[2]), 16'(wlog[3])}, 64'h0000_0008_0010_0018);
    chk(mem[1] == gold[1] && mem[2] == gold[2], "R9 evicted data in memory", mem[1], gold[1]);
    chk(rd == gold[12'h200 >> 3], "R3 load after eviction", rd, gold[12'h200 >> 3]);
    op(2'b01, 0, 12'h080, 0, 0);
    chk(d_lr == 0, "R8 rotation spared way 1", 64'(d_lr), 0);
    op(2'b01, 0, 12'h000, 0, 0);
    chk(d_lr == 1 && d_wr == 0 && rd == gold[0], "R9 clean victim no write", 64'(d_wr), 0);

    for (int k = 0; k < 400; k++) begin
      bit wr = $urandom_range(1) == 1;
      logic [7:0] be = 8'($urandom);
      logic [63:0] d = {$urandom, $urandom};
      if ($urandom_range(4) == 0) begin
        logic [11:0] a = {1'b1, 11'($urandom)};
        op(2'b00, wr, a, d, be);
        if (wr) chk(mem[a[11:3]] == gold[a[11:3]] && d_wr == 1, "R2 random uncached write", mem[a[11:3]], gold[a[11:3]]);
        else chk(rd == gold[a[11:3]] && d_lr == 0, "R1 random uncached read", rd, gold[a[11:3]]);
      end else begin
        logic [11:0] a = {2'b00, 3'($urandom), 2'($urandom), 2'($urandom), 3'b000};
        logic [1:0] pol = $urandom_range(1) ? 2'b10 : 2'b01;
        op(pol, wr, a, d, be);
        if (!wr) begin
          chk(rd == gold[a[11:3]], "R3 random load data", rd, gold[a[11:3]]);
          chk(rp == bp(rd), "R10 random parity", {56'b0, rp}, {56'b0, bp(rd)});
        end else if (pol == 2'b10)
          chk((mem[a[11:3]] & bemask(be)) == (d & bemask(be)), "R6 random wt beat", mem[a[11:3]] & bemask(be), d & bemask(be));
        else
          chk(d_wr == 0 || d_wr == 4, "R4 random wb store traffic", 64'(d_wr), 0);
      end
    end
    summary();
  end
endmodule